// File: doc/BRIEF.md
# External Bus Area Chip-Select Controller

This block sits between a 32-bit CPU-side request port and a shared 16-bit static-memory bus. It maps the CPU byte address onto five external areas and drives one active-low select per area. For the selected area it applies that area's data width, strobe wait length and recovery gap. A CPU access wider than the area's data width is split into consecutive beats, lowest address first.

Two address-map layouts can be selected with a single input. In the split layout, the two highest areas occupy only the upper half of their 64 MB slots. In the full layout, every area spans a whole slot. A second input selects the byte order for every area at once.

The CPU raises a one-cycle request. At most one access is in flight. A one-cycle ready pulse returns the read data, or flags an address that no area claims.

Top module: `extbus_area_ctrl`

## Requirements
- R1: With `map_full`=0, the slots at 0x0000_0000, 0x0C00_0000 and 0x1000_0000 are claimed in full (64 MB each) by select bits 0, 1 and 2. Select bits 3 and 4 claim only the upper 32 MB of the slots at 0x1400_0000 and 0x1800_0000 (offset bit 25 set).
- R2: With `map_full`=1, select bits 3 and 4 claim the whole 64 MB of their slots. `ext_addr` carries the byte offset within the slot.
- R3: An address claimed by no area asserts no select. It returns `cpu_ready` and `cpu_err` together, one cycle after the request, with `cpu_rdata`=0.
- R4: At most one select is low at any time. A select is low exactly when `ext_rd_n` or `ext_wr_n` is low. The two strobes are never low together.
- R5: Each beat holds its strobe for 1 + N cycles, where N is the area's 4-bit field `cfg_wait[4a+3:4a]`.
- R6: `cpu_size` 0/1/2 means 1/2/4 bytes; the access address is aligned down to its size. An area with `cfg_wide[a]`=1 (16-bit) needs ceil(bytes/2) beats; an 8-bit area needs one beat per byte. Beats are back to back at rising addresses.
- R7: CPU data is right-justified. With `big_endian`=0, the lowest address is the least significant byte. With `big_endian`=1, it is the most significant byte of the access. On a 16-bit area, an even address uses `ext_dout/ext_din[7:0]` when little-endian and `[15:8]` when big-endian; an odd address uses the other lane.
- R8: `ext_be_n[l]` is low only for lanes carrying bytes of the access. An 8-bit area always uses lane 0 only (`ext_be_n`=2'b10).
- R9: The 2-bit gap `cfg_idle[2p+1:2p]` of the previous area p inserts that many select-free cycles before the strobe. This happens when the new access targets another area or the previous access was a read. There is no gap after a write to the same area, and none for the first access after reset.
- R10: `cpu_ready` is high for exactly one cycle, right after the last strobe cycle. A request raised while an access is in flight is ignored.
- R11: During and after reset, all selects and strobes are high, `ext_be_n`=2'b11 and `cpu_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_full | input | 1 | 0: split layout for areas 3 and 4; 1: full-slot layout |
| big_endian | input | 1 | Byte order for every area |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_rdata | output | 32 | Right-justified read data, valid with ready |
| cpu_ready | output | 1 | Completion pulse |
| cpu_err | output | 1 | Unmapped address, with ready |
| cfg_wide | input | 5 | Per-area width, 1 = 16 bit |
| cfg_wait | input | 20 | Per-area strobe wait, 4 bits each |
| cfg_idle | input | 10 | Per-area recovery gap, 2 bits each |
| ext_cs_n | output | 5 | Active-low area selects |
| ext_addr | output | 26 | Byte offset within the slot |
| ext_rd_n | output | 1 | Read strobe |
| ext_wr_n | output | 1 | Write strobe |
| ext_be_n | output | 2 | Active-low lane enables |
| ext_dout | output | 16 | Write data lanes |
| ext_din | input | 16 | Read data lanes |

## Verification
A wrong beat or wait counter shows up as a strobe run of the wrong length. The ready pulse then comes earlier or later than the cycle count predicted from the width, wait and gap settings, and this is visible on the access itself. A stale previous-area or previous-direction record shows up as a missing or extra gap, and so as a latency off by the recovery count on the very next access. A wrong lane choice writes bytes into the wrong addresses of the bench memory. This is caught when the bench compares the memory right after the write, or when a later read-back returns swapped data.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GAP    = 2'd1,
        ST_STROBE = 2'd2,
        ST_DONE   = 2'd3
    } bus_st_e;

    // byte count of a CPU access from its size code
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        return sz[1] ? 3'd4 : (sz[0] ? 3'd2 : 3'd1);
    endfunction
endpackage

// File: rtl/extbus_area_decode.sv
module extbus_area_decode #(
    parameter int ADDR_W    = 32,
    parameter int SLOT_W    = 26,
    parameter int NUM_AREAS = 5,
    localparam int IDX_W    = $clog2(NUM_AREAS),
    localparam int SEL_W    = ADDR_W - SLOT_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_full,
    output logic              hit,
    output logic [IDX_W-1:0]  area_idx,
    output logic [SLOT_W-1:0] offset
);
    // slot number claimed by each area, in select-bit order
    function automatic int slot_of(input int a);
        case (a)
            0:       return 0;
            1:       return 3;
            2:       return 4;
            3:       return 5;
            default: return 6;
        endcase
    endfunction

    logic [NUM_AREAS-1:0] match;

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        localparam int  SLOT    = slot_of(g);
        localparam bit  HALFMAP = (g >= 3);
        assign match[g] = (addr[ADDR_W-1:SLOT_W] == SEL_W'(SLOT))
                        && (!HALFMAP || map_full || addr[SLOT_W-1]);
    end

    always_comb begin
        area_idx = '0;
        for (int i = 0; i < NUM_AREAS; i++) begin
            if (match[i]) area_idx = IDX_W'(i);
        end
    end

    assign hit    = |match;
    assign offset = addr[SLOT_W-1:0];
endmodule

// File: rtl/extbus_lane_map.sv
module extbus_lane_map #(
    parameter int SLOT_W = 26
) (
    input  logic              wide,
    input  logic              big,
    input  logic [2:0]        nbytes,
    input  logic [SLOT_W-1:0] base,
    input  logic [SLOT_W-1:0] beat_addr,
    input  logic [31:0]       wdata,
    output logic [15:0]       dout,
    output logic [1:0]        lane_en,
    output logic [1:0][1:0]   lane_pos
);
    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [SLOT_W-1:0] byte_addr;
        logic [SLOT_W-1:0] rel;
        logic [2:0]        pos_full;

        assign byte_addr   = wide ? {beat_addr[SLOT_W-1:1], 1'(l) ^ big} : beat_addr;
        assign rel         = byte_addr - base;
        assign lane_en[l]  = (wide || (l == 0)) && (rel < SLOT_W'(nbytes));
        assign pos_full    = big ? (nbytes - 3'd1 - rel[2:0]) : rel[2:0];
        assign lane_pos[l] = pos_full[1:0];
        assign dout[8*l +: 8] = lane_en[l] ? wdata[8*lane_pos[l] +: 8] : 8'h00;
    end
endmodule

// File: rtl/extbus_area_ctrl.sv
module extbus_area_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int SLOT_W    = 26,
    parameter int NUM_AREAS = 5,
    parameter int WAIT_W    = 4,
    parameter int IDLE_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        map_full,
    input  logic                        big_endian,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [1:0]                  cpu_size,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [31:0]                 cpu_wdata,
    output logic [31:0]                 cpu_rdata,
    output logic                        cpu_ready,
    output logic                        cpu_err,
    input  logic [NUM_AREAS-1:0]        cfg_wide,
    input  logic [NUM_AREAS*WAIT_W-1:0] cfg_wait,
    input  logic [NUM_AREAS*IDLE_W-1:0] cfg_idle,
    output logic [NUM_AREAS-1:0]        ext_cs_n,
    output logic [SLOT_W-1:0]           ext_addr,
    output logic                        ext_rd_n,
    output logic                        ext_wr_n,
    output logic [1:0]                  ext_be_n,
    output logic [15:0]                 ext_dout,
    input  logic [15:0]                 ext_din
);
    import extbus_pkg::*;

    localparam int IDX_W = $clog2(NUM_AREAS);

    typedef struct packed {
        bus_st_e           st;
        logic [IDX_W-1:0]  area;
        logic              we;
        logic [2:0]        nbytes;
        logic [SLOT_W-1:0] base;
        logic [1:0]        beat;
        logic [1:0]        last_beat;
        logic [WAIT_W-1:0] cnt;
        logic [IDLE_W-1:0] gap;
        logic [31:0]       wdata;
        logic [31:0]       rdata;
        logic              err;
        logic [IDX_W-1:0]  prev_area;
        logic              prev_rd;
        logic              has_prev;
    } ctl_t;

    ctl_t q, d;

    logic              dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    logic [SLOT_W-1:0] dec_off;
    logic [2:0]        nb_in;
    logic              cur_wide;
    logic [WAIT_W-1:0] cur_wait;
    logic [SLOT_W-1:0] beat_addr;
    logic [15:0]       lane_dout;
    logic [1:0]        lane_en;
    logic [1:0][1:0]   lane_pos;
    logic              strobing;

    extbus_area_decode #(
        .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .NUM_AREAS(NUM_AREAS)
    ) u_decode (
        .addr(cpu_addr), .map_full(map_full),
        .hit(dec_hit), .area_idx(dec_idx), .offset(dec_off)
    );

    assign nb_in     = size_bytes(cpu_size);
    assign cur_wide  = cfg_wide[q.area];
    assign cur_wait  = cfg_wait[q.area*WAIT_W +: WAIT_W];
    assign beat_addr = q.base + (cur_wide ? SLOT_W'({q.beat, 1'b0}) : SLOT_W'(q.beat));

    extbus_lane_map #(.SLOT_W(SLOT_W)) u_lanes (
        .wide(cur_wide), .big(big_endian), .nbytes(q.nbytes), .base(q.base),
        .beat_addr(beat_addr), .wdata(q.wdata),
        .dout(lane_dout), .lane_en(lane_en), .lane_pos(lane_pos)
    );

    always_comb begin
        logic              need_gap;
        logic [IDLE_W-1:0] prev_idle;
        logic [WAIT_W-1:0] new_wait;
        d         = q;
        need_gap  = q.has_prev && (q.prev_rd || (q.prev_area != dec_idx));
        prev_idle = cfg_idle[q.prev_area*IDLE_W +: IDLE_W];
        new_wait  = cfg_wait[dec_idx*WAIT_W +: WAIT_W];
        case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.rdata  = '0;
                    d.we     = cpu_we;
                    d.wdata  = cpu_wdata;
                    d.nbytes = nb_in;
                    d.area   = dec_idx;
                    d.base   = dec_off & ~(SLOT_W'(nb_in) - SLOT_W'(1));
                    d.beat   = '0;
                    d.cnt    = new_wait;
                    if (!dec_hit) begin
                        d.err = 1'b1;
                        d.st  = ST_DONE;
                    end else begin
                        d.err       = 1'b0;
                        d.last_beat = cfg_wide[dec_idx] ? ((nb_in == 3'd4) ? 2'd1 : 2'd0)
                                                        : 2'(nb_in - 3'd1);
                        if (need_gap && (prev_idle != '0)) begin
                            d.st  = ST_GAP;
                            d.gap = prev_idle - IDLE_W'(1);
                        end else begin
                            d.st  = ST_STROBE;
                        end
                        d.prev_area = dec_idx;
                        d.prev_rd   = !cpu_we;
                        d.has_prev  = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (q.gap == '0) d.st  = ST_STROBE;
                else             d.gap = q.gap - IDLE_W'(1);
            end
            ST_STROBE: begin
                if (!q.we) begin
                    for (int l = 0; l < 2; l++) begin
                        if (lane_en[l]) d.rdata[8*lane_pos[l] +: 8] = ext_din[8*l +: 8];
                    end
                end
                if (q.cnt == '0) begin
                    if (q.beat == q.last_beat) begin
                        d.st = ST_DONE;
                    end else begin
                        d.beat = q.beat + 2'd1;
                        d.cnt  = cur_wait;
                    end
                end else begin
                    d.cnt = q.cnt - WAIT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign strobing = (q.st == ST_STROBE);

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cs
        assign ext_cs_n[g] = !(strobing && (q.area == IDX_W'(g)));
    end

    assign ext_addr  = beat_addr;
    assign ext_rd_n  = !(strobing && !q.we);
    assign ext_wr_n  = !(strobing && q.we);
    assign ext_be_n  = strobing ? ~lane_en : 2'b11;
    assign ext_dout  = (strobing && q.we) ? lane_dout : 16'h0000;
    assign cpu_ready = (q.st == ST_DONE);
    assign cpu_err   = (q.st == ST_DONE) && q.err;
    assign cpu_rdata = (q.st == ST_DONE) ? q.rdata : 32'h0;
endmodule

// File: rtl/extbus_area_ctrl_chk.sv
module extbus_area_ctrl_chk #(
    parameter int NUM_AREAS = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_AREAS-1:0] ext_cs_n,
    input logic                 ext_rd_n,
    input logic                 ext_wr_n,
    input logic [1:0]           ext_be_n,
    input logic [NUM_AREAS-1:0] cfg_wide,
    input logic                 cpu_ready,
    input logic                 cpu_err,
    input logic [31:0]          cpu_rdata
);
    logic any_sel;
    logic narrow_sel;

    assign any_sel    = (ext_cs_n != '1);
    assign narrow_sel = |(~ext_cs_n & ~cfg_wide);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n)); // R4
    AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> any_sel); // R4
    AST_SELECT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        any_sel |-> (!ext_rd_n || !ext_wr_n)); // R4
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n)); // R4
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R10
    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> cpu_ready); // R3
    AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> (!any_sel && ($past(ext_cs_n) == '1))); // R3
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> (cpu_rdata == 32'h0)); // R3
    AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_sel |-> (ext_be_n == 2'b10)); // R8
    AST_IDLE_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !any_sel |-> (ext_be_n == 2'b11)); // R11
endmodule

bind extbus_area_ctrl extbus_area_ctrl_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_be_n(ext_be_n), .cfg_wide(cfg_wide),
    .cpu_ready(cpu_ready), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata)
);

// File: tb/extbus_area_ctrl_bench.sv
`timescale 1ns/1ps
module extbus_area_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_full = 1'b0;
    logic        big_endian = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = 32'h0;
    logic [31:0] cpu_wdata = 32'h0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        cpu_err;
    logic [4:0]  cfg_wide;
    logic [19:0] cfg_wait;
    logic [9:0]  cfg_idle;
    logic [4:0]  ext_cs_n;
    logic [25:0] ext_addr;
    logic        ext_rd_n;
    logic        ext_wr_n;
    logic [1:0]  ext_be_n;
    logic [15:0] ext_dout;
    logic [15:0] ext_din;

    always #10 clk = ~clk;

    extbus_area_ctrl u_extbus_area_ctrl (
        .clk(clk), .rst_n(rst_n), .map_full(map_full), .big_endian(big_endian),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
        .cfg_wide(cfg_wide), .cfg_wait(cfg_wait), .cfg_idle(cfg_idle),
        .ext_cs_n(ext_cs_n), .ext_addr(ext_addr), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_be_n(ext_be_n), .ext_dout(ext_dout), .ext_din(ext_din)
    );

    // per-area settings (select-bit order)
    bit [4:0] wide_set = 5'b10101;
    int wait_set [5] = '{1, 0, 3, 2, 0};
    int idle_set [5] = '{2, 1, 0, 3, 1};

    logic [7:0] mem [0:4][0:255];

    int checks = 0;
    int fails  = 0;
    int stray  = 0;

    typedef struct {
        string       rq;
        logic [31:0] rd;
        bit          err;
        int          lat;
        int          stb;
    } exp_t;
    exp_t sb_q[$];

    bit has_prev = 0;
    bit prev_rd  = 0;
    int prev_ar  = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // external memory model: reads
    always_comb begin
        ext_din = 16'h0000;
        for (int a = 0; a < 5; a++) begin
            if (!ext_cs_n[a]) begin
                if (wide_set[a]) begin
                    ext_din[7:0]  = mem[a][{ext_addr[7:1], big_endian}];
                    ext_din[15:8] = mem[a][{ext_addr[7:1], !big_endian}];
                end else begin
                    ext_din[7:0]  = mem[a][ext_addr[7:0]];
                end
            end
        end
    end

    // external memory model: writes
    always @(negedge clk) begin
        if (rst_n && !ext_wr_n) begin
            for (int a = 0; a < 5; a++) begin
                if (!ext_cs_n[a]) begin
                    if (wide_set[a]) begin
                        if (!ext_be_n[0]) mem[a][{ext_addr[7:1], big_endian}]  = ext_dout[7:0];
                        if (!ext_be_n[1]) mem[a][{ext_addr[7:1], !big_endian}] = ext_dout[15:8];
                    end else if (!ext_be_n[0]) begin
                        mem[a][ext_addr[7:0]] = ext_dout[7:0];
                    end
                end
            end
        end
    end

    // monitor: measures latency and strobe cycles, compares against scoreboard
    initial begin
        bit in_flight = 0;
        int lat = 0;
        int stb = 0;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (!in_flight && cpu_req) begin
                    in_flight = 1;
                    lat = 0;
                    stb = 0;
                end
                if (in_flight) begin
                    lat++;
                    if (!ext_rd_n || !ext_wr_n) stb++;
                end
                if (cpu_ready) begin
                    if (!in_flight || sb_q.size() == 0) begin
                        stray++;
                        chk(0, "R10", "unexpected ready", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        chk(lat == e.lat, e.rq, "ready latency", lat, e.lat);
                        chk(stb == e.stb, e.rq, "strobe cycles", stb, e.stb);
                        chk(cpu_err == e.err, e.rq, "error flag", cpu_err, e.err);
                        chk(cpu_rdata == e.rd, e.rq, "read data", cpu_rdata, e.rd);
                        in_flight = 0;
                    end
                end
            end
        end
    end

    // driver: computes expected timing from the requirements and issues one access
    task automatic access(input string rq, input logic [31:0] a, input logic w,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input logic [31:0] exp_rd, input bit exp_err, input int ar,
                          input bit poke_busy);
        exp_t e;
        int nb, beats, gap;
        e.rq  = rq;
        e.rd  = exp_rd;
        e.err = exp_err;
        if (exp_err) begin
            e.lat = 1;
            e.stb = 0;
        end else begin
            nb    = 1 << sz;
            beats = wide_set[ar] ? ((nb == 1) ? 1 : nb / 2) : nb;
            e.stb = beats * (1 + wait_set[ar]);
            gap   = (has_prev && (prev_rd || prev_ar != ar)) ? idle_set[prev_ar] : 0;
            e.lat = gap + e.stb + 1;
            has_prev = 1;
            prev_rd  = !w;
            prev_ar  = ar;
        end
        sb_q.push_back(e);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_we = w; cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        if (poke_busy) begin
            cpu_req = 1'b1; cpu_addr = 32'h1000_0080; cpu_we = 1'b1;
            cpu_size = 2'd0; cpu_wdata = 32'h99;
            @(negedge clk);
            cpu_req = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < 5; a++)
            for (int i = 0; i < 256; i++) mem[a][i] = 8'h00;
        mem[1][8'h20] = 8'h12; mem[1][8'h21] = 8'h34;
        mem[1][8'h22] = 8'h56; mem[1][8'h23] = 8'h78;
        mem[3][8'h40] = 8'h5A; mem[3][8'h02] = 8'h3C;
        mem[4][8'h11] = 8'h77;
        cfg_wide = wide_set;
        for (int a = 0; a < 5; a++) begin
            cfg_wait[4*a +: 4] = 4'(wait_set[a]);
            cfg_idle[2*a +: 2] = 2'(idle_set[a]);
        end

        repeat (3) @(negedge clk);
        // R11: reset state
        chk(ext_cs_n == 5'h1F, "R11", "selects in reset", ext_cs_n, 5'h1F);
        chk(ext_rd_n && ext_wr_n, "R11", "strobes in reset", {ext_rd_n, ext_wr_n}, 2'b11);
        chk(ext_be_n == 2'b11, "R11", "lane enables in reset", ext_be_n, 2'b11);
        chk(!cpu_ready, "R11", "ready in reset", cpu_ready, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // split layout, little endian
        access("R1 R5 R6 R9", 32'h0000_0010, 1, 2, 32'h1122_3344, 0, 0, 0, 0);
        chk({mem[0][8'h13], mem[0][8'h12], mem[0][8'h11], mem[0][8'h10]} == 32'h1122_3344,
            "R7", "little word on 16-bit area", {mem[0][8'h13], mem[0][8'h12], mem[0][8'h11], mem[0][8'h10]}, 32'h1122_3344);
        access("R7 R9", 32'h0000_0010, 0, 2, 0, 32'h1122_3344, 0, 0, 0);
        access("R9", 32'h0000_0010, 0, 2, 0, 32'h1122_3344, 0, 0, 0);
        access("R1 R8 R9", 32'h0C00_0005, 1, 0, 32'hA5, 0, 0, 1, 0);
        chk(mem[1][8'h05] == 8'hA5, "R8", "byte write on 8-bit area", mem[1][8'h05], 8'hA5);
        access("R6 R7", 32'h0C00_0020, 0, 1, 0, 32'h3412, 0, 1, 0);
        access("R3", 32'h0400_0000, 0, 2, 0, 0, 1, 0, 0);
        access("R1 R3", 32'h1400_0000, 0, 0, 0, 0, 1, 0, 0);
        access("R1 R5", 32'h1600_0040, 0, 0, 0, 32'h5A, 0, 3, 0);
        access("R1 R3", 32'h1800_0000, 0, 0, 0, 0, 1, 0, 0);

        // full layout
        map_full = 1'b1;
        access("R2 R7", 32'h1800_0011, 0, 0, 0, 32'h77, 0, 4, 0);
        access("R2 R9", 32'h1400_0002, 0, 0, 0, 32'h3C, 0, 3, 0);

        // big endian
        big_endian = 1'b1;
        access("R5 R6 R9", 32'h1000_0020, 1, 2, 32'hCAFE_BABE, 0, 0, 2, 0);
        chk({mem[2][8'h20], mem[2][8'h21], mem[2][8'h22], mem[2][8'h23]} == 32'hCAFE_BABE,
            "R7", "big word on 16-bit area", {mem[2][8'h20], mem[2][8'h21], mem[2][8'h22], mem[2][8'h23]}, 32'hCAFE_BABE);
        access("R7", 32'h1000_0022, 0, 1, 0, 32'h0000_BABE, 0, 2, 0);
        access("R6 R7", 32'h0C00_0020, 0, 2, 0, 32'h1234_5678, 0, 1, 0);

        // request while busy is ignored
        access("R10", 32'h0000_0030, 1, 1, 32'h0000_BEEF, 0, 0, 0, 1);
        repeat (12) @(negedge clk);
        chk(stray == 0, "R10", "stray ready count", stray, 0);
        chk(mem[2][8'h80] == 8'h00, "R10", "ignored request wrote memory", mem[2][8'h80], 8'h00);
        chk({mem[0][8'h30], mem[0][8'h31]} == 16'hBEEF, "R7", "big halfword write",
            {mem[0][8'h30], mem[0][8'h31]}, 16'hBEEF);

        // narrow word write, little endian
        big_endian = 1'b0;
        access("R6 R8 R9", 32'h1400_0010, 1, 2, 32'h0102_0304, 0, 0, 3, 0);
        chk({mem[3][8'h13], mem[3][8'h12], mem[3][8'h11], mem[3][8'h10]} == 32'h0102_0304,
            "R7", "little word on 8-bit area", {mem[3][8'h13], mem[3][8'h12], mem[3][8'h11], mem[3][8'h10]}, 32'h0102_0304);

        summary();
        $finish;
    end
endmodule